// File: doc/BRIEF.md
# Parallel Pascal Row Binomial Engine

The engine computes the binomial coefficient C(n,k) by building the rows of Pascal's triangle one after another. It holds one row in a single register array with entries 0 to MAX_N. A bank of processing elements, one per entry, produces every entry of the next row in the same pass. Each pass has two cycles. In the first, every element captures its pair of neighbouring entries from the previous row into private registers. In the second, the whole new row is written back at once. Because of this split, no element ever reads an entry that has already been updated in the same pass.

A caller presents n and k with a one-cycle start strobe while the engine is idle. Passes i = 0 to n follow. In pass i, only entries at or below both i and k are updated: the two ends of the row become 1, and each interior entry becomes the sum of its left neighbour and itself from the previous row. When the last pass ends, a one-cycle done pulse is raised and the result is taken from entry k. A sticky flag reports that some addition carried out of the result width. The result itself is then the value modulo 2^RES_W.

Top module: `pascal_binom_engine`

## Requirements
- R1: After reset, done_o and ovf_o are 0 and result_o is 0.
- R2: start_i is accepted only while idle. A start pulse during a computation has no effect: done timing, result_o and ovf_o of the running job are unchanged.
- R3: For 0 <= k <= n <= MAX_N, result_o equals C(n,k) mod 2^RES_W when done_o is high.
- R4: With k <= n, done_o rises for exactly one cycle on the (2n+3)th rising edge, counting the edge that samples start_i as the first. Each of the n+1 passes takes two cycles.
- R5: With k > n, no pass runs. done_o is high for one cycle right after the edge that samples start_i, with result_o = 0 and ovf_o = 0.
- R6: ovf_o is cleared by an accepted start. It becomes 1 and stays 1 if any addition on an entry with index <= k, in any pass, produces a sum of at least 2^RES_W. ovf_o is valid together with done_o.
- R7: The boundary cases C(n,0), C(n,n) and C(0,0) all yield 1. This holds because the row is cleared at start and entries above the pass index stay 0.
- R8: After done_o, result_o and ovf_o hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled while idle |
| n_i | input | $clog2(MAX_N+1) | Row number n |
| k_i | input | $clog2(MAX_N+1) | Column k |
| result_o | output | RES_W | Row entry k, holding C(n,k) once done |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Sticky flag: some addition exceeded RES_W bits |

## Verification
A wrong entry anywhere in the row array spreads to higher indices in later passes, but result_o shows only entry k. A corrupted low entry therefore becomes visible at the done pulse up to n passes later, either as a wrong coefficient or as a spurious overflow flag. A pass counter or phase error shows sooner and more directly: done_o fires on the wrong cycle, and the bench checks that on every clock. Start pulses injected mid-run and runs with k > n expose any leak of the start path into a busy computation.

// File: rtl/binom_pkg.sv
package binom_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;
endpackage

// File: rtl/binom_pe.sv
module binom_pe #(
    parameter int RES_W = 12,
    parameter int NW    = 4,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NW-1:0]    pass_i,
    input  logic [NW-1:0]    k_i,
    input  logic [RES_W-1:0] left_i,
    input  logic [RES_W-1:0] self_i,
    output logic             act_o,
    output logic [RES_W-1:0] val_o,
    output logic             cy_o
);
    localparam logic [NW-1:0] MY_IDX = NW'(IDX);

    typedef struct packed {
        logic [RES_W-1:0] lhs;
        logic [RES_W-1:0] rhs;
    } pe_regs_t;

    pe_regs_t pe_d, pe_q;
    logic [RES_W:0] sum_w;
    logic           end_w;

    always_comb begin
        pe_d = pe_q;
        if (load_i) begin
            pe_d.lhs = left_i;
            pe_d.rhs = self_i;
        end
        sum_w = {1'b0, pe_q.lhs} + {1'b0, pe_q.rhs};
        end_w = (MY_IDX == '0) || (MY_IDX == pass_i);
        act_o = (MY_IDX <= pass_i) && (MY_IDX <= k_i);
        val_o = end_w ? RES_W'(1) : sum_w[RES_W-1:0];
        cy_o  = act_o && !end_w && sum_w[RES_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pe_q <= '0;
        else        pe_q <= pe_d;
    end
endmodule

// File: rtl/binom_ctrl.sv
module binom_ctrl
    import binom_pkg::*;
#(
    parameter int NW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [NW-1:0] n_i,
    input  logic [NW-1:0] k_i,
    output logic          clear_o,
    output logic          load_o,
    output logic          write_o,
    output logic [NW-1:0] pass_o,
    output logic [NW-1:0] k_o,
    output logic          done_o
);
    typedef struct packed {
        phase_e        phase;
        logic [NW-1:0] pass;
        logic [NW-1:0] n;
        logic [NW-1:0] k;
        logic          done;
    } ctrl_t;

    ctrl_t ct_d, ct_q;

    always_comb begin
        ct_d      = ct_q;
        ct_d.done = 1'b0;
        unique case (ct_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    ct_d.n    = n_i;
                    ct_d.k    = k_i;
                    ct_d.pass = '0;
                    if (k_i > n_i) ct_d.done  = 1'b1;
                    else           ct_d.phase = PH_LOAD;
                end
            end
            PH_LOAD: ct_d.phase = PH_WRITE;
            PH_WRITE: begin
                if (ct_q.pass == ct_q.n) begin
                    ct_d.phase = PH_IDLE;
                    ct_d.done  = 1'b1;
                end else begin
                    ct_d.pass  = ct_q.pass + 1'b1;
                    ct_d.phase = PH_LOAD;
                end
            end
            default: ct_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ct_q <= '{phase: PH_IDLE, pass: '0, n: '0, k: '0, done: 1'b0};
        else        ct_q <= ct_d;
    end

    assign clear_o = (ct_q.phase == PH_IDLE) && start_i;
    assign load_o  = (ct_q.phase == PH_LOAD);
    assign write_o = (ct_q.phase == PH_WRITE);
    assign pass_o  = ct_q.pass;
    assign k_o     = ct_q.k;
    assign done_o  = ct_q.done;

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ct_q.done |=> !ct_q.done);

    assert_pass_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.phase != PH_IDLE) |-> (ct_q.pass <= ct_q.n));

    assert_busy_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.phase != PH_IDLE && start_i) |=> ($stable(ct_q.n) && $stable(ct_q.k)));
endmodule

// File: rtl/pascal_binom_engine.sv
module pascal_binom_engine #(
    parameter int MAX_N = 15,
    parameter int RES_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_i,
    input  logic [$clog2(MAX_N+1)-1:0]     n_i,
    input  logic [$clog2(MAX_N+1)-1:0]     k_i,
    output logic [RES_W-1:0]               result_o,
    output logic                           done_o,
    output logic                           ovf_o
);
    localparam int NW   = $clog2(MAX_N + 1);
    localparam int ROWS = MAX_N + 1;

    typedef struct {
        logic [RES_W-1:0] row [ROWS];
        logic             ovf;
    } eng_t;

    eng_t eng_d, eng_q;

    logic          clear_w, load_w, write_w;
    logic [NW-1:0] pass_w, k_w;
    logic [ROWS-1:0]  act_w, cy_w;
    logic [RES_W-1:0] val_w [ROWS];

    binom_ctrl #(.NW(NW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .n_i     (n_i),
        .k_i     (k_i),
        .clear_o (clear_w),
        .load_o  (load_w),
        .write_o (write_w),
        .pass_o  (pass_w),
        .k_o     (k_w),
        .done_o  (done_o)
    );

    for (genvar j = 0; j < ROWS; j++) begin : g_pe
        logic [RES_W-1:0] left_w;
        if (j == 0) begin : g_first
            assign left_w = '0;
        end else begin : g_rest
            assign left_w = eng_q.row[j-1];
        end
        binom_pe #(.RES_W(RES_W), .NW(NW), .IDX(j)) u_pe (
            .clk    (clk),
            .rst_n  (rst_n),
            .load_i (load_w),
            .pass_i (pass_w),
            .k_i    (k_w),
            .left_i (left_w),
            .self_i (eng_q.row[j]),
            .act_o  (act_w[j]),
            .val_o  (val_w[j]),
            .cy_o   (cy_w[j])
        );
    end

    always_comb begin
        eng_d = eng_q;
        if (clear_w) begin
            for (int j = 0; j < ROWS; j++) eng_d.row[j] = '0;
            eng_d.ovf = 1'b0;
        end else if (write_w) begin
            for (int j = 0; j < ROWS; j++) begin
                if (act_w[j]) eng_d.row[j] = val_w[j];
            end
            if (|cy_w) eng_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int j = 0; j < ROWS; j++) eng_q.row[j] <= '0;
            eng_q.ovf <= 1'b0;
        end else begin
            for (int j = 0; j < ROWS; j++) eng_q.row[j] <= eng_d.row[j];
            eng_q.ovf <= eng_d.ovf;
        end
    end

    assign result_o = eng_q.row[k_w];
    assign ovf_o    = eng_q.ovf;

    assert_row_end_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        write_w |=> (eng_q.row[0] == RES_W'(1)));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.ovf && !clear_w) |=> eng_q.ovf);

    assert_clear_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_w |=> (eng_q.row[MAX_N] == '0 && !eng_q.ovf));

    assert_hold_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(result_o) && $stable(ovf_o)));
endmodule

// File: tb/pascal_binom_engine_bench.sv
module pascal_binom_engine_bench;
    localparam int MAX_N = 15;
    localparam int RES_W = 12;
    localparam int NW    = $clog2(MAX_N + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [NW-1:0]    n_i = '0;
    logic [NW-1:0]    k_i = '0;
    logic [RES_W-1:0] result_o;
    logic             done_o;
    logic             ovf_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    pascal_binom_engine #(.MAX_N(MAX_N), .RES_W(RES_W)) u_pascal_binom_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .n_i(n_i), .k_i(k_i),
        .result_o(result_o), .done_o(done_o), .ovf_o(ovf_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected < 100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: whole rows of Pascal's triangle with wrapping sums.
    task automatic model(input int n, input int k, output int res, output bit ovf);
        int cur [MAX_N+1];
        int nxt [MAX_N+1];
        int lim;
        lim = 1 << RES_W;
        ovf = 1'b0;
        foreach (cur[j]) cur[j] = 0;
        if (k > n) begin
            res = 0;
            return;
        end
        for (int i = 0; i <= n; i++) begin
            nxt = cur;
            for (int j = 0; j <= i && j <= k; j++) begin
                if (j == 0 || j == i) nxt[j] = 1;
                else begin
                    nxt[j] = cur[j-1] + cur[j];
                    if (nxt[j] >= lim) begin
                        ovf = 1'b1;
                        nxt[j] = nxt[j] % lim;
                    end
                end
            end
            cur = nxt;
        end
        res = cur[k];
    endtask

    task automatic run(input int n, input int k, input bit inject, input string req);
        int  er;
        bit  eo;
        int  lat;
        model(n, k, er, eo);
        lat = (k > n) ? 1 : 2 * n + 3;
        @(negedge clk);
        start_i = 1'b1;
        n_i = NW'(n);
        k_i = NW'(k);
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 1; c <= lat + 1; c++) begin
            check(done_o == (c == lat), (k > n) ? "R5" : "R4",
                  $sformatf("done n=%0d k=%0d cycle %0d", n, k, c), done_o, (c == lat));
            if (c == lat) begin
                check(result_o == RES_W'(er), req,
                      $sformatf("result n=%0d k=%0d", n, k), result_o, er);
                check(ovf_o == eo, "R6", $sformatf("ovf n=%0d k=%0d", n, k), ovf_o, eo);
            end
            if (inject && c == 3) begin
                start_i = 1'b1;
                n_i = NW'(3);
                k_i = NW'(1);
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        for (int h = 0; h < 3; h++) @(negedge clk);
        check(result_o == RES_W'(er), "R8", "result held after done", result_o, er);
        check(ovf_o == eo, "R8", "ovf held after done", ovf_o, eo);
        check(done_o == 1'b0, "R8", "done stays low while idle", done_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R1", "done in reset", done_o, 0);
        check(result_o == '0, "R1", "result in reset", result_o, 0);
        check(ovf_o == 1'b0, "R1", "ovf in reset", ovf_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o == 1'b0 && ovf_o == 1'b0, "R1", "idle after reset", done_o, 0);

        run(5, 2, 1'b0, "R3");
        run(6, 3, 1'b0, "R3");
        run(10, 5, 1'b0, "R3");
        run(0, 0, 1'b0, "R7");
        run(4, 0, 1'b0, "R7");
        run(7, 7, 1'b0, "R7");
        run(15, 7, 1'b0, "R3");   // wraps, R6 sets flag
        run(3, 5, 1'b0, "R5");    // k > n, flag cleared by start
        run(15, 2, 1'b0, "R3");
        run(15, 15, 1'b0, "R7");  // result 1 while an inner sum overflowed
        run(8, 4, 1'b1, "R2");    // start injected while busy must be ignored
        run(2, 1, 1'b0, "R3");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule